// File: doc/BRIEF.md
# SIMD Lane Byte-Align Unit

This datapath block takes two vector operands and, separately inside each 128-bit lane, joins a lane of the first operand above the matching lane of the second. It then slides that 32-byte pair toward byte zero by an unsigned byte count and keeps the lowest 16 bytes. No byte ever moves from one lane into another. A count that runs past the end of the joined pair gives a zero lane.

A mode input sets how the upper lane is handled. In wide mode both lanes are aligned with the same count. In narrow mode only the low lane is aligned and the upper lane is cleared. In legacy mode the low lane's first operand is the old destination value, and the upper lane passes that old destination value through unchanged.

Operands enter on a valid/ready handshake and the result leaves on another, one register stage later. A result that is not yet taken stays on the outputs until `out_ready` is seen high. While a result is stalled, no new operands are accepted.

Top module: `lane_align_unit`

## Requirements
- R1: For each aligned lane, result byte k (0..15) equals byte k+n of a 32-byte pair. In that pair bytes 0..15 are the lane of `src_b` and bytes 16..31 are the lane's first operand; n is `shift_imm`.
- R2: `shift_imm` is unsigned (0..255). Any pair index of 32 or more gives byte 0x00, so a count of 32 or larger gives an all-zero aligned lane.
- R3: With `mode` = 2'b10 (wide), both lanes use `src_a` as first operand and the same count. Lane 0 (bits 127:0) uses only bits 127:0 of the operands; lane 1 (bits 255:128) uses only bits 255:128.
- R4: With `mode` = 2'b01 (narrow) or the spare code 2'b11, lane 0 is aligned from `src_a`/`src_b` and result bits 255:128 are zero.
- R5: With `mode` = 2'b00 (legacy), lane 0's first operand is `prior_dst[127:0]`, `src_a` has no effect, and result bits 255:128 equal `prior_dst[255:128]`.
- R6: Operands accepted at a clock edge (`in_valid` and `in_ready` high) appear on `result` with `out_valid` high after that same edge, one cycle of latency.
- R7: While `out_valid` is high and `out_ready` is low, `result` and `out_valid` hold and `in_ready` is low. Otherwise `in_ready` is high.
- R8: After reset `out_valid` is low and `result` is zero.
- R9: A count of 0 returns the `src_b` lane unchanged; a count of 16 returns the first-operand lane unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operands offered |
| in_ready | output | 1 | Operands can be taken this cycle |
| src_a | input | 256 | First operand (upper half of each lane pair) |
| src_b | input | 256 | Second operand (lower half of each lane pair) |
| prior_dst | input | 256 | Current destination contents, used in legacy mode |
| shift_imm | input | 8 | Unsigned byte count |
| mode | input | 2 | 00 legacy, 01 narrow, 10 wide, 11 as narrow |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result this cycle |
| result | output | 256 | Aligned result |

## Verification
Each lane of the operands is filled with a distinct byte pattern, so every result byte shows which operand, lane and byte position it came from. A count of 0 or 16 tells a correct lane pass-through from an off-by-one window. Counts of 5, 21 and 31 check windows that straddle the two halves of the pair or sit near its end. Counts of 32 and 255 check the zero flush. Wide, narrow, spare and legacy codes are tried against the same patterns: a lane leaking into its neighbour, a wrong upper-half rule, or `src_a` used in legacy mode each gives a different byte mismatch. A stalled-consumer sequence confirms that the held result is not overwritten by a newly offered operand set.

// File: rtl/lane_align_pkg.sv
package lane_align_pkg;
  typedef enum logic [1:0] {
    MODE_LEGACY = 2'd0,
    MODE_NARROW = 2'd1,
    MODE_WIDE   = 2'd2,
    MODE_SPARE  = 2'd3
  } mode_e;
endpackage

// File: rtl/la_lane_window.sv
// One lane: byte k of the window is byte k+count of {first, second}, zero beyond the pair.
module la_lane_window #(
  parameter int LANE_BYTES = 16,
  parameter int CNT_W      = 8
) (
  input  logic [LANE_BYTES*8-1:0] first_i,
  input  logic [LANE_BYTES*8-1:0] second_i,
  input  logic [CNT_W-1:0]        count_i,
  output logic [LANE_BYTES*8-1:0] win_o
);
  localparam int PAIR_BYTES = 2 * LANE_BYTES;
  localparam int IDX_W      = $clog2(PAIR_BYTES);
  localparam int SUM_W      = CNT_W + 1;

  logic [7:0] pair_byte [PAIR_BYTES];

  for (genvar p = 0; p < PAIR_BYTES; p++) begin : g_pair
    if (p < LANE_BYTES) begin : g_low
      assign pair_byte[p] = second_i[p*8 +: 8];
    end else begin : g_high
      assign pair_byte[p] = first_i[(p-LANE_BYTES)*8 +: 8];
    end
  end

  for (genvar k = 0; k < LANE_BYTES; k++) begin : g_byte
    logic [SUM_W-1:0] idx;
    assign idx = {1'b0, count_i} + SUM_W'(k);
    always_comb begin
      if (idx < SUM_W'(PAIR_BYTES)) begin
        win_o[k*8 +: 8] = pair_byte[idx[IDX_W-1:0]];
      end else begin
        win_o[k*8 +: 8] = 8'h00;
      end
    end
  end
endmodule

// File: rtl/la_operand_mux.sv
// Picks each lane's first operand: legacy mode feeds lane 0 from the destination.
module la_operand_mux
  import lane_align_pkg::*;
#(
  parameter int NUM_LANES = 2,
  parameter int LANE_W    = 128
) (
  input  logic [NUM_LANES*LANE_W-1:0] src_a_i,
  input  logic [NUM_LANES*LANE_W-1:0] prior_i,
  input  mode_e                       mode_i,
  output logic [NUM_LANES*LANE_W-1:0] first_o
);
  for (genvar l = 0; l < NUM_LANES; l++) begin : g_lane
    if (l == 0) begin : g_base
      assign first_o[l*LANE_W +: LANE_W] = (mode_i == MODE_LEGACY)
                                         ? prior_i[l*LANE_W +: LANE_W]
                                         : src_a_i[l*LANE_W +: LANE_W];
    end else begin : g_upper
      assign first_o[l*LANE_W +: LANE_W] = src_a_i[l*LANE_W +: LANE_W];
    end
  end
endmodule

// File: rtl/la_result_merge.sv
// Applies the per-mode rule to the lanes above lane 0.
module la_result_merge
  import lane_align_pkg::*;
#(
  parameter int NUM_LANES = 2,
  parameter int LANE_W    = 128
) (
  input  logic [NUM_LANES*LANE_W-1:0] window_i,
  input  logic [NUM_LANES*LANE_W-1:0] prior_i,
  input  mode_e                       mode_i,
  output logic [NUM_LANES*LANE_W-1:0] merged_o
);
  for (genvar l = 0; l < NUM_LANES; l++) begin : g_lane
    if (l == 0) begin : g_base
      assign merged_o[l*LANE_W +: LANE_W] = window_i[l*LANE_W +: LANE_W];
    end else begin : g_upper
      always_comb begin
        unique case (mode_i)
          MODE_WIDE:   merged_o[l*LANE_W +: LANE_W] = window_i[l*LANE_W +: LANE_W];
          MODE_LEGACY: merged_o[l*LANE_W +: LANE_W] = prior_i[l*LANE_W +: LANE_W];
          default:     merged_o[l*LANE_W +: LANE_W] = '0;
        endcase
      end
    end
  end
endmodule

// File: rtl/la_out_stage.sv
// Single register stage with valid/ready on both sides.
module la_out_stage #(
  parameter int DATA_W = 256
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] data_i,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DATA_W-1:0] data_o
);
  assign in_ready = !out_valid || out_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      data_o    <= '0;
    end else if (in_ready) begin
      out_valid <= in_valid;
      if (in_valid) begin
        data_o <= data_i;
      end
    end
  end
endmodule

// File: rtl/lane_align_unit.sv
module lane_align_unit
  import lane_align_pkg::*;
#(
  parameter int NUM_LANES  = 2,
  parameter int LANE_BYTES = 16,
  parameter int CNT_W      = 8
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            in_valid,
  output logic                            in_ready,
  input  logic [NUM_LANES*LANE_BYTES*8-1:0] src_a,
  input  logic [NUM_LANES*LANE_BYTES*8-1:0] src_b,
  input  logic [NUM_LANES*LANE_BYTES*8-1:0] prior_dst,
  input  logic [CNT_W-1:0]                shift_imm,
  input  logic [1:0]                      mode,
  output logic                            out_valid,
  input  logic                            out_ready,
  output logic [NUM_LANES*LANE_BYTES*8-1:0] result
);
  localparam int LANE_W = LANE_BYTES * 8;
  localparam int DATA_W = NUM_LANES * LANE_W;

  mode_e             mode_q;
  logic [DATA_W-1:0] first_op;
  logic [DATA_W-1:0] window;
  logic [DATA_W-1:0] merged;

  assign mode_q = mode_e'(mode);

  la_operand_mux #(.NUM_LANES(NUM_LANES), .LANE_W(LANE_W)) u_opmux (
    .src_a_i (src_a),
    .prior_i (prior_dst),
    .mode_i  (mode_q),
    .first_o (first_op)
  );

  for (genvar l = 0; l < NUM_LANES; l++) begin : g_lane
    la_lane_window #(.LANE_BYTES(LANE_BYTES), .CNT_W(CNT_W)) u_win (
      .first_i  (first_op[l*LANE_W +: LANE_W]),
      .second_i (src_b[l*LANE_W +: LANE_W]),
      .count_i  (shift_imm),
      .win_o    (window[l*LANE_W +: LANE_W])
    );
  end

  la_result_merge #(.NUM_LANES(NUM_LANES), .LANE_W(LANE_W)) u_merge (
    .window_i (window),
    .prior_i  (prior_dst),
    .mode_i   (mode_q),
    .merged_o (merged)
  );

  la_out_stage #(.DATA_W(DATA_W)) u_out (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .data_i    (merged),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .data_o    (result)
  );
endmodule

// File: rtl/lane_align_unit_chk.sv
module lane_align_unit_chk #(
  parameter int DATA_W     = 256,
  parameter int LANE_BYTES = 16,
  parameter int CNT_W      = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic              in_ready,
  input logic [DATA_W-1:0] src_a,
  input logic [DATA_W-1:0] src_b,
  input logic [DATA_W-1:0] prior_dst,
  input logic [CNT_W-1:0]  shift_imm,
  input logic [1:0]        mode,
  input logic              out_valid,
  input logic              out_ready,
  input logic [DATA_W-1:0] result
);
  localparam int LANE_W = LANE_BYTES * 8;
  logic take;
  assign take = in_valid && in_ready;

  // R6
  accept_to_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> out_valid);

  // R7
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(result)));

  // R7
  stall_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |-> !in_ready);

  // R4
  narrow_upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (take && (mode == 2'b01 || mode == 2'b11)) |=> (result[DATA_W-1:LANE_W] == '0));

  // R5
  legacy_upper_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (take && mode == 2'b00) |=> (result[DATA_W-1:LANE_W] == $past(prior_dst[DATA_W-1:LANE_W])));

  // R2
  flush_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (take && mode == 2'b10 && shift_imm >= CNT_W'(2*LANE_BYTES)) |=> (result == '0));

  // R9
  zero_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (take && mode == 2'b10 && shift_imm == '0) |=> (result == $past(src_b)));

  // R9
  lane_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (take && mode == 2'b10 && shift_imm == CNT_W'(LANE_BYTES)) |=> (result == $past(src_a)));
endmodule

bind lane_align_unit lane_align_unit_chk #(
  .DATA_W     (NUM_LANES*LANE_BYTES*8),
  .LANE_BYTES (LANE_BYTES),
  .CNT_W      (CNT_W)
) chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .src_a     (src_a),
  .src_b     (src_b),
  .prior_dst (prior_dst),
  .shift_imm (shift_imm),
  .mode      (mode),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .result    (result)
);

// File: tb/lane_align_unit_tb_top.sv
`timescale 1ns/1ps
module lane_align_unit_tb_top;
  typedef struct packed {
    logic [1:0] mode;
    logic [7:0] imm;
    logic [7:0] seed;
  } vec_t;

  localparam int NVEC = 15;
  localparam vec_t VECS [NVEC] = '{
    '{2'b10, 8'd0,   8'd1},
    '{2'b10, 8'd16,  8'd2},
    '{2'b10, 8'd5,   8'd3},
    '{2'b10, 8'd21,  8'd4},
    '{2'b10, 8'd31,  8'd5},
    '{2'b10, 8'd32,  8'd6},
    '{2'b10, 8'd255, 8'd7},
    '{2'b10, 8'd1,   8'd8},
    '{2'b01, 8'd3,   8'd9},
    '{2'b01, 8'd17,  8'd10},
    '{2'b11, 8'd9,   8'd11},
    '{2'b00, 8'd4,   8'd12},
    '{2'b00, 8'd20,  8'd13},
    '{2'b00, 8'd40,  8'd14},
    '{2'b00, 8'd16,  8'd15}
  };

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         in_valid = 1'b0;
  logic         out_ready = 1'b1;
  logic [255:0] src_a = '0, src_b = '0, prior_dst = '0;
  logic [7:0]   shift_imm = '0;
  logic [1:0]   mode = 2'b10;
  logic         in_ready, out_valid;
  logic [255:0] result;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #2.5 clk = ~clk;

  lane_align_unit dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .src_a(src_a), .src_b(src_b), .prior_dst(prior_dst), .shift_imm(shift_imm),
    .mode(mode), .out_valid(out_valid), .out_ready(out_ready), .result(result)
  );

  function automatic logic [255:0] pat(input logic [7:0] seed, input logic [7:0] salt);
    logic [255:0] v;
    for (int i = 0; i < 32; i++) begin
      v[i*8 +: 8] = 8'(seed*7 + salt*31 + i*13) ^ 8'(i << 3);
    end
    return v;
  endfunction

  function automatic logic [127:0] lane_ref(input logic [127:0] hi, input logic [127:0] lo,
                                            input logic [7:0] n);
    logic [255:0] pair;
    pair = {hi, lo};
    if (n >= 8'd32) return '0;
    pair = pair >> (int'(n) * 8);
    return pair[127:0];
  endfunction

  function automatic logic [255:0] model(input logic [1:0] m, input logic [7:0] n,
      input logic [255:0] a, input logic [255:0] b, input logic [255:0] d);
    logic [127:0] lo, hi;
    lo = lane_ref((m == 2'b00) ? d[127:0] : a[127:0], b[127:0], n);
    case (m)
      2'b10:   hi = lane_ref(a[255:128], b[255:128], n);
      2'b00:   hi = d[255:128];
      default: hi = '0;
    endcase
    return {hi, lo};
  endfunction

  task automatic check(input string tag, input logic [255:0] got, input logic [255:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  task automatic drive(input vec_t v);
    src_a     = pat(v.seed, 8'd1);
    src_b     = pat(v.seed, 8'd2);
    prior_dst = pat(v.seed, 8'd3);
    shift_imm = v.imm;
    mode      = v.mode;
  endtask

  initial begin
    logic [255:0] exp_a;
    logic [255:0] exp_b;
    repeat (3) @(negedge clk);
    // R8: reset state
    check("R8 out_valid", {255'd0, out_valid}, 256'd0);
    check("R8 result", result, '0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NVEC; i++) begin
      string tag;
      drive(VECS[i]);
      in_valid = 1'b1;
      if (VECS[i].imm >= 8'd32)                               tag = "R2";
      else if (VECS[i].mode == 2'b00)                          tag = "R5";
      else if (VECS[i].mode != 2'b10)                          tag = "R4";
      else if (VECS[i].imm == 8'd0 || VECS[i].imm == 8'd16)    tag = "R9";
      else if (VECS[i].imm < 8'd16)                            tag = "R1";
      else                                                     tag = "R3";
      exp_a = model(VECS[i].mode, VECS[i].imm, src_a, src_b, prior_dst);
      @(negedge clk);
      in_valid = 1'b0;
      check({tag, " R6 valid"}, {255'd0, out_valid}, 256'd1);
      check(tag, result, exp_a);
    end

    // R3: lanes do not mix: only upper-lane operand changes, lower result must not move
    src_a = '0; src_b = '0; src_a[255:128] = {16{8'hA5}}; src_b[255:128] = {16{8'h3C}};
    shift_imm = 8'd8; mode = 2'b10; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check("R3 no cross lane", result, {{8{8'hA5}}, {8{8'h3C}}, 128'd0});

    // R5: src_a ignored in legacy mode
    prior_dst = pat(8'd50, 8'd3); src_b = pat(8'd50, 8'd2); src_a = {32{8'hFF}};
    shift_imm = 8'd24; mode = 2'b00; in_valid = 1'b1;
    exp_a = model(2'b00, 8'd24, '0, src_b, prior_dst);
    @(negedge clk);
    in_valid = 1'b0;
    check("R5 src_a ignored", result, exp_a);

    // R7: back-pressure sequence
    @(negedge clk);
    out_ready = 1'b0;
    drive('{2'b10, 8'd7, 8'd60});
    exp_a = model(2'b10, 8'd7, src_a, src_b, prior_dst);
    in_valid = 1'b1;
    @(negedge clk);
    drive('{2'b10, 8'd11, 8'd61});
    exp_b = model(2'b10, 8'd11, src_a, src_b, prior_dst);
    check("R7 first held", result, exp_a);
    check("R7 in_ready low", {255'd0, in_ready}, 256'd0);
    @(negedge clk);
    check("R7 still held", result, exp_a);
    check("R7 valid held", {255'd0, out_valid}, 256'd1);
    out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check("R7 second after release", result, exp_b);
    @(negedge clk);
    check("R6 valid drops", {255'd0, out_valid}, 256'd0);

    // R8: reset mid-stream clears output
    drive('{2'b10, 8'd2, 8'd70});
    in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    rst_n = 1'b0;
    @(negedge clk);
    check("R8 reset result", result, '0);
    check("R8 reset valid", {255'd0, out_valid}, 256'd0);
    rst_n = 1'b1;
    @(negedge clk);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    #(5.0 * 20000);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog got=timeout exp=completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule